// File: doc/BRIEF.md
# Branch Target Buffer

This block is a small direct-mapped cache that the fetch stage searches in the same cycle with the current program counter. Each slot remembers a branch's address tag, where that branch last went, and a 2-bit saturating confidence counter. When the fetch address matches a valid slot whose counter leans toward taken, the block redirects fetch to the stored target. In every other case it hands back the sequential address, fetch PC plus four.

A second port, driven by the execute stage when a branch resolves, trains the buffer. A taken branch that is not yet present claims its slot, evicting whatever was there, with a weakly-taken counter. A branch that is already present moves its counter one step toward its outcome, and if it was taken its target is refreshed. A not-taken branch that is absent leaves the buffer alone. Training writes land at the next rising clock edge, so a lookup in the same cycle sees the older contents.

Top module: `branch_target_buf`

## Requirements
- R1: When the lookup misses, `pred_redirect` is 0 and `pred_next_pc` equals `fetch_pc + 4`, wrapping modulo 2^32 (0xFFFFFFFC gives 0x00000000).
- R2: A synchronous active-high `rst` marks every slot invalid, so every lookup on the cycle after reset misses.
- R3: A lookup hits when the slot at index `fetch_pc[7:2]` is valid and its stored tag equals `fetch_pc[31:8]`. On a hit whose counter bit 1 is 1 (values 2'b10 and 2'b11), `pred_redirect` is 1 and `pred_next_pc` is the stored target. On a hit whose counter bit 1 is 0, the output is the same as on a miss.
- R4: A resolved taken branch that misses writes its slot with valid set, its tag, its target and counter 2'b10. This replaces any earlier occupant of that index.
- R5: A resolved taken branch that hits stores the new target and raises the counter by one, holding at 2'b11.
- R6: A resolved not-taken branch that hits lowers the counter by one, holding at 2'b00, and keeps the stored target.
- R7: A resolved not-taken branch that misses changes no slot.
- R8: Training writes take effect at the next rising clock edge. A lookup in the same cycle as the write returns the result from the contents before the write.
- R9: Two addresses that share index bits [7:2] but differ in bits [31:8] never use each other's slot. Slots at different indices are independent of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | input | 32 | Address being fetched this cycle |
| pred_redirect | output | 1 | High when fetch should go to the stored target |
| pred_next_pc | output | 32 | Predicted next fetch address |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Resolved direction, 1 = taken |
| upd_target | input | 32 | Resolved target of the branch |

## Verification
The assertions assume `upd_valid`, `upd_taken` and the address inputs are known (not X) at every rising edge once reset is released. They also assume training traffic reflects real branch outcomes, so a redirect to a freshly written slot must point at the target just supplied. The bench drives every input to a defined value at the falling edge and holds it through the next rising edge. It issues at most one training write per cycle and asserts reset only on cycle boundaries, which keeps the stimulus inside those assumptions.

// File: rtl/btb_pkg.sv
package btb_pkg;

    parameter int PC_W   = 32;
    parameter int IDX_W  = 6;
    parameter int CTR_W  = 2;

    localparam int ENTRIES = 1 << IDX_W;
    localparam int LO_W    = 2;
    localparam int TAG_W   = PC_W - IDX_W - LO_W;

    typedef logic [PC_W-1:0]  pc_t;
    typedef logic [TAG_W-1:0] tag_t;
    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [CTR_W-1:0] ctr_t;

    localparam ctr_t CTR_MAX   = '1;
    localparam ctr_t CTR_MIN   = '0;
    localparam ctr_t CTR_ALLOC = ctr_t'(1) << (CTR_W - 1);

    typedef struct packed {
        tag_t tag;
        pc_t  target;
        ctr_t ctr;
    } slot_t;

    typedef struct packed {
        logic  en;
        idx_t  idx;
        slot_t data;
    } slot_wr_t;

    function automatic idx_t idx_of(input pc_t pc);
        return pc[LO_W +: IDX_W];
    endfunction

    function automatic tag_t tag_of(input pc_t pc);
        return pc[PC_W-1 -: TAG_W];
    endfunction

    function automatic pc_t seq_pc(input pc_t pc);
        return pc + pc_t'(4);
    endfunction

    function automatic ctr_t ctr_up(input ctr_t c);
        return (c == CTR_MAX) ? c : c + ctr_t'(1);
    endfunction

    function automatic ctr_t ctr_dn(input ctr_t c);
        return (c == CTR_MIN) ? c : c - ctr_t'(1);
    endfunction

    function automatic logic ctr_taken(input ctr_t c);
        return c[CTR_W-1];
    endfunction

endpackage

// File: rtl/btb_store.sv
module btb_store
    import btb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  slot_wr_t wr,
    input  idx_t     rd_a_idx,
    output logic     rd_a_vld,
    output slot_t    rd_a,
    input  idx_t     rd_b_idx,
    output logic     rd_b_vld,
    output slot_t    rd_b
);

    logic [ENTRIES-1:0] valid_q;
    slot_t              slot_q [ENTRIES];
    logic [ENTRIES-1:0] wr_sel;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_dec
        assign wr_sel[g] = wr.en && (wr.idx == idx_t'(g));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else begin
            valid_q <= valid_q | wr_sel;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (!rst && wr_sel[i]) begin
                slot_q[i] <= wr.data;
            end
        end
    end

    assign rd_a_vld = valid_q[rd_a_idx];
    assign rd_a     = slot_q[rd_a_idx];
    assign rd_b_vld = valid_q[rd_b_idx];
    assign rd_b     = slot_q[rd_b_idx];

    // R2: the cycle after reset no slot is valid
    a_r2_clear_all: assert property (@(posedge clk)
        $past(rst) |-> (valid_q == '0));

    // R7: valid bits only change through a write or reset
    a_r7_valid_quiet: assert property (@(posedge clk) disable iff (rst)
        !wr.en |=> $stable(valid_q));

endmodule

// File: rtl/btb_lookup.sv
module btb_lookup
    import btb_pkg::*;
(
    input  pc_t   fetch_pc,
    input  logic  slot_vld,
    input  slot_t slot,
    output logic  hit,
    output logic  redirect,
    output pc_t   next_pc
);

    always_comb begin
        hit      = slot_vld && (slot.tag == tag_of(fetch_pc));
        redirect = hit && ctr_taken(slot.ctr);
        next_pc  = redirect ? slot.target : seq_pc(fetch_pc);
    end

    // R3: a redirect never occurs without a valid matching slot
    always_comb begin
        if (redirect) begin
            a_r3_tag_gate: assert (slot_vld && slot.tag == tag_of(fetch_pc));
        end
    end

endmodule

// File: rtl/btb_update.sv
module btb_update
    import btb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     upd_valid,
    input  pc_t      upd_pc,
    input  logic     upd_taken,
    input  pc_t      upd_target,
    input  logic     slot_vld,
    input  slot_t    slot,
    output slot_wr_t wr
);

    logic hit;

    always_comb begin
        hit          = slot_vld && (slot.tag == tag_of(upd_pc));
        wr.en        = 1'b0;
        wr.idx       = idx_of(upd_pc);
        wr.data.tag  = tag_of(upd_pc);
        wr.data.target = slot.target;
        wr.data.ctr  = slot.ctr;
        if (upd_valid) begin
            if (hit) begin
                wr.en = 1'b1;
                if (upd_taken) begin
                    wr.data.target = upd_target;
                    wr.data.ctr    = ctr_up(slot.ctr);
                end else begin
                    wr.data.ctr    = ctr_dn(slot.ctr);
                end
            end else if (upd_taken) begin
                wr.en          = 1'b1;
                wr.data.target = upd_target;
                wr.data.ctr    = CTR_ALLOC;
            end
        end
    end

    a_r4_alloc_weak: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && upd_taken && !hit) |-> (wr.en && wr.data.ctr == CTR_ALLOC));

    a_r5_sat_high: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && upd_taken && hit && slot.ctr == CTR_MAX) |-> (wr.data.ctr == CTR_MAX));

    a_r6_sat_low: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && !upd_taken && hit && slot.ctr == CTR_MIN) |-> (wr.data.ctr == CTR_MIN));

    a_r6_keep_target: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && !upd_taken && hit) |-> (wr.data.target == slot.target));

    a_r7_no_alloc: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && !upd_taken && !hit) |-> !wr.en);

endmodule

// File: rtl/branch_target_buf.sv
module branch_target_buf
    import btb_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] fetch_pc,
    output logic            pred_redirect,
    output logic [PC_W-1:0] pred_next_pc,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    input  logic [PC_W-1:0] upd_target
);

    slot_wr_t wr;
    logic     look_vld, upd_vld;
    slot_t    look_slot, upd_slot;
    logic     look_hit;

    btb_store u_store (
        .clk      (clk),
        .rst      (rst),
        .wr       (wr),
        .rd_a_idx (idx_of(fetch_pc)),
        .rd_a_vld (look_vld),
        .rd_a     (look_slot),
        .rd_b_idx (idx_of(upd_pc)),
        .rd_b_vld (upd_vld),
        .rd_b     (upd_slot)
    );

    btb_lookup u_lookup (
        .fetch_pc (fetch_pc),
        .slot_vld (look_vld),
        .slot     (look_slot),
        .hit      (look_hit),
        .redirect (pred_redirect),
        .next_pc  (pred_next_pc)
    );

    btb_update u_update (
        .clk        (clk),
        .rst        (rst),
        .upd_valid  (upd_valid),
        .upd_pc     (upd_pc),
        .upd_taken  (upd_taken),
        .upd_target (upd_target),
        .slot_vld   (upd_vld),
        .slot       (upd_slot),
        .wr         (wr)
    );

    // R2: nothing redirects on the first cycle after reset
    a_r2_cold_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !pred_redirect);

    // R8: a redirect right after a taken training write of that address uses its target
    a_r8_fresh_target: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(upd_valid && upd_taken) && fetch_pc == $past(upd_pc)
         && pred_redirect) |-> (pred_next_pc == $past(upd_target)));

    // R1: no hit means the sequential address
    a_r1_miss_seq: assert property (@(posedge clk) disable iff (rst)
        !look_hit |-> (!pred_redirect && pred_next_pc == fetch_pc + 32'd4));

endmodule

// File: tb/tb_branch_target_buf.sv
module tb_branch_target_buf;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] fetch_pc;
    logic        pred_redirect;
    logic [31:0] pred_next_pc;
    logic        upd_valid;
    logic [31:0] upd_pc;
    logic        upd_taken;
    logic [31:0] upd_target;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    branch_target_buf dut (
        .clk           (clk),
        .rst           (rst),
        .fetch_pc      (fetch_pc),
        .pred_redirect (pred_redirect),
        .pred_next_pc  (pred_next_pc),
        .upd_valid     (upd_valid),
        .upd_pc        (upd_pc),
        .upd_taken     (upd_taken),
        .upd_target    (upd_target)
    );

    typedef struct packed {
        logic        en;
        logic        tk;
        logic [31:0] upc;
        logic [31:0] utgt;
        logic [31:0] fpc;
        logic        ered;
        logic [31:0] enext;
    } vec_t;

    localparam int NV = 25;
    localparam logic [31:0] JUNK = 32'hDEAD_0000;

    // expected outputs are the lookup before this vector's training edge
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 32'h0,        32'h0,    32'h1000,     1'b0, 32'h1004},   // R2
        '{1'b1, 1'b0, 32'h1000,     32'h2000, 32'h1000,     1'b0, 32'h1004},   // R7
        '{1'b0, 1'b0, 32'h0,        32'h0,    32'h1000,     1'b0, 32'h1004},   // R7
        '{1'b1, 1'b1, 32'h1000,     32'h2000, 32'h1000,     1'b0, 32'h1004},   // R8
        '{1'b0, 1'b0, 32'h0,        32'h0,    32'h1000,     1'b1, 32'h2000},   // R4
        '{1'b0, 1'b0, 32'h0,        32'h0,    32'h2000,     1'b0, 32'h2004},   // R9
        '{1'b1, 1'b0, 32'h1000,     JUNK,     32'h1000,     1'b1, 32'h2000},   // R6
        '{1'b0, 1'b0, 32'h0,        32'h0,    32'h1000,     1'b0, 32'h1004},   // R3
        '{1'b1, 1'b1, 32'h1000,     32'h3000, 32'h1004,     1'b0, 32'h1008},   // R1
        '{1'b0, 1'b0, 32'h0,        32'h0,    32'h1000,     1'b1, 32'h3000},   // R5
        '{1'b1, 1'b1, 32'h1000,     32'h3000, 32'h1000,     1'b1, 32'h3000},   // R5
        '{1'b1, 1'b1, 32'h1000,     32'h3000, 32'h1000,     1'b1, 32'h3000},   // R5
        '{1'b1, 1'b0, 32'h1000,     JUNK,     32'h1000,     1'b1, 32'h3000},   // R6
        '{1'b0, 1'b0, 32'h0,        32'h0,    32'h1000,     1'b1, 32'h3000},   // R5
        '{1'b1, 1'b0, 32'h1000,     JUNK,     32'h1000,     1'b1, 32'h3000},   // R6
        '{1'b1, 1'b0, 32'h1000,     JUNK,     32'h1000,     1'b0, 32'h1004},   // R6
        '{1'b1, 1'b0, 32'h1000,     JUNK,     32'h1000,     1'b0, 32'h1004},   // R6
        '{1'b1, 1'b1, 32'h1000,     32'h3000, 32'h1000,     1'b0, 32'h1004},   // R6
        '{1'b0, 1'b0, 32'h0,        32'h0,    32'h1000,     1'b0, 32'h1004},   // R6
        '{1'b1, 1'b1, 32'h2000,     32'h5000, 32'h2000,     1'b0, 32'h2004},   // R4
        '{1'b0, 1'b0, 32'h0,        32'h0,    32'h2000,     1'b1, 32'h5000},   // R4
        '{1'b0, 1'b0, 32'h0,        32'h0,    32'h1000,     1'b0, 32'h1004},   // R4
        '{1'b1, 1'b1, 32'h10FC,     32'h0800, 32'h10FC,     1'b0, 32'h1100},   // R1
        '{1'b0, 1'b0, 32'h0,        32'h0,    32'h10FC,     1'b1, 32'h0800},   // R9
        '{1'b0, 1'b0, 32'h0,        32'h0,    32'hFFFF_FFFC, 1'b0, 32'h0000}   // R1
    };

    function automatic string req_of(input int i);
        case (i)
            0:                      return "R2";
            1, 2:                   return "R7";
            3:                      return "R8";
            4, 19, 20, 21:          return "R4";
            5, 23:                  return "R9";
            7:                      return "R3";
            8, 22, 24:              return "R1";
            9, 10, 11, 13:          return "R5";
            default:                return "R6";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic en, input logic tk, input logic [31:0] upc,
                         input logic [31:0] utgt, input logic [31:0] fpc);
        @(negedge clk);
        upd_valid  = en;
        upd_taken  = tk;
        upd_pc     = upc;
        upd_target = utgt;
        fetch_pc   = fpc;
        #1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
        $finish;
    end

    initial begin : main
        rst = 1'b1;
        upd_valid = 1'b0; upd_taken = 1'b0; upd_pc = '0; upd_target = '0;
        fetch_pc = 32'h1000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].en, VECS[i].tk, VECS[i].upc, VECS[i].utgt, VECS[i].fpc);
            check(req_of(i), {31'b0, pred_redirect}, {31'b0, VECS[i].ered},
                  $sformatf("vec %0d redirect", i));
            check(req_of(i), pred_next_pc, VECS[i].enext,
                  $sformatf("vec %0d next_pc", i));
        end

        // R2: mid-run reset forgets learned slots, even with a taken write pending
        @(negedge clk);
        rst = 1'b1;
        upd_valid = 1'b1; upd_taken = 1'b1; upd_pc = 32'h40; upd_target = 32'h80;
        @(negedge clk);
        rst = 1'b0;
        upd_valid = 1'b0;
        fetch_pc = 32'h10FC;
        #1;
        check("R2", {31'b0, pred_redirect}, 32'd0, "reset slot 63 redirect");
        check("R2", pred_next_pc, 32'h1100, "reset slot 63 next_pc");
        fetch_pc = 32'h40;
        #1;
        check("R2", pred_next_pc, 32'h44, "write during reset dropped");

        // R8: a taken write becomes visible exactly one edge later
        drive(1'b1, 1'b1, 32'h40, 32'h80, 32'h40);
        check("R8", pred_next_pc, 32'h44, "same-cycle lookup old");
        drive(1'b0, 1'b0, 32'h0, 32'h0, 32'h40);
        check("R8", {31'b0, pred_redirect}, 32'd1, "next-cycle redirect");
        check("R8", pred_next_pc, 32'h80, "next-cycle target");

        // R9: neighbouring index unaffected
        drive(1'b0, 1'b0, 32'h0, 32'h0, 32'h44);
        check("R9", pred_next_pc, 32'h48, "neighbour index miss");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule